// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches a word carried on dual-rail wiring, two wires per bit, and reports with a single `done` output when the word has fully arrived or has fully drained back to the empty (spacer) state. Each bit's two rails are ORed into a per-bit "present" flag. The flags are merged by a hysteretic N-input hold cell that behaves like a Muller C-element, modelled here with one register. The cell sets when every flag is high and clears when every flag is low. In any mixed state it keeps its value, so `done` never toggles while a word is only partly written or partly cleared.

While `done` is high, the block also presents the arriving word as plain binary. It raises a combinational flag whenever any bit shows the illegal code with both rails high. Upstream logic drives the rails in the usual four-phase manner: spacer, then valid, then spacer again. Downstream logic waits on `done` for each transition.

Top module: `dr_done_detect`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) forces `done` to 0 after that edge.
- R2: Bit i is coded as {`rail_hi[i]`,`rail_lo[i]`}: 00 is the spacer, 01 is logic 0, 10 is logic 1 and 11 is illegal. A bit counts as present when either rail is high.
- R3: When every bit is present at a rising edge, `done` is 1 after that edge.
- R4: When every bit is the spacer at a rising edge, `done` is 0 after that edge.
- R5: When some bits are present and some are not, `done` keeps its previous value across the edge, whether that value is 0 or 1.
- R6: `word` equals `rail_hi` while `done` is 1, and it is all zeros while `done` is 0.
- R7: `illegal` is 1, combinationally, whenever at least one bit carries code 11. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| rail_hi | input | W | High rail of each bit (logic 1 when set alone) |
| rail_lo | input | W | Low rail of each bit (logic 0 when set alone) |
| done | output | 1 | Completion output of the hold cell |
| word | output | W | Decoded binary word, zero while `done` is low |
| illegal | output | 1 | Some bit carries the unused code 11 |

## Verification
Words are filled from spacer to valid one bit at a time, in a shuffled order, for all-zero, all-one and mixed values. After each step `done` must stay low, and it must rise only on the edge after the last bit arrives. This separates a true C-element from an OR-style or AND-style merge that reacts to partial words. The drain runs in a different shuffled order, and `done` must stay high until the final bit clears, which exposes any merge that drops early. Separate tests cover a single illegal code among spacers, and a reset applied while the word is valid followed by recovery.

// File: rtl/dr_done_detect.sv
module dr_done_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rail_hi,
  input  logic [W-1:0] rail_lo,
  output logic         done,
  output logic [W-1:0] word,
  output logic         illegal
);

  logic [W-1:0] present;
  logic         all_in;
  logic         none_in;

  assign present = rail_hi | rail_lo;
  assign all_in  = &present;
  assign none_in = ~|present;

  always_ff @(posedge clk) begin
    if (rst)          done <= 1'b0;
    else if (all_in)  done <= 1'b1;
    else if (none_in) done <= 1'b0;
  end

  assign word    = done ? rail_hi : '0;
  assign illegal = |(rail_hi & rail_lo);

  a_r1_reset: assert property (@(posedge clk) rst |=> !done);
  a_r3_rise: assert property (@(posedge clk) disable iff (rst)
    all_in |=> done);
  a_r4_fall: assert property (@(posedge clk) disable iff (rst)
    none_in |=> !done);
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!all_in && !none_in) |=> $stable(done));
  a_r6_word: assert property (@(posedge clk) disable iff (rst)
    (done && !illegal) |-> ((word & rail_lo) == '0));

endmodule

// File: tb/tb_dr_done_detect.sv
module tb_dr_done_detect;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] rail_hi, rail_lo;
  logic         done, illegal;
  logic [W-1:0] word;
  int           checks = 0;
  int           errors = 0;
  int           cycles = 0;

  dr_done_detect #(.W(W)) dut (
    .clk(clk), .rst(rst), .rail_hi(rail_hi), .rail_lo(rail_lo),
    .done(done), .word(word), .illegal(illegal)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic shuffle(output int ord[W]);
    for (int i = 0; i < W; i++) ord[i] = i;
    for (int i = W - 1; i > 0; i--) begin
      int j;
      int t;
      j = $urandom_range(i, 0);
      t = ord[i]; ord[i] = ord[j]; ord[j] = t;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; rail_hi = '0; rail_lo = '0;
    step(); step();
    chk("R1 done after reset", {{(W-1){1'b0}}, done}, '0);
    chk("R6 word zero after reset", word, '0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_fill_drain(input logic [W-1:0] value);
    int ord[W];
    shuffle(ord);
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      if (value[ord[k]]) rail_hi[ord[k]] = 1'b1;
      else               rail_lo[ord[k]] = 1'b1;
      step();
      if (k < W - 1) begin
        chk("R5 done held low while partial", {{(W-1){1'b0}}, done}, '0);
        chk("R6 word zero while not done", word, '0);
      end else begin
        chk("R3 done rises when complete", {{(W-1){1'b0}}, done}, 1);
        chk("R6 word decoded", word, value);
        chk("R2 R7 no illegal on valid word", {{(W-1){1'b0}}, illegal}, '0);
      end
    end
    shuffle(ord);
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      rail_hi[ord[k]] = 1'b0;
      rail_lo[ord[k]] = 1'b0;
      step();
      if (k < W - 1)
        chk("R5 done held high while draining", {{(W-1){1'b0}}, done}, 1);
      else begin
        chk("R4 done falls when all spacer", {{(W-1){1'b0}}, done}, '0);
        chk("R6 word zero after drain", word, '0);
      end
    end
  endtask

  task automatic t_illegal();
    @(negedge clk);
    rail_hi = '0; rail_lo = '0;
    rail_hi[3] = 1'b1; rail_lo[3] = 1'b1;
    #1;
    chk("R7 illegal on code 11", {{(W-1){1'b0}}, illegal}, 1);
    step();
    chk("R5 partial 11 keeps done low", {{(W-1){1'b0}}, done}, '0);
    @(negedge clk);
    rail_lo[3] = 1'b0;
    #1;
    chk("R7 illegal clears", {{(W-1){1'b0}}, illegal}, '0);
    @(negedge clk);
    rail_hi = '0;
    step();
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rail_hi = 8'hA5; rail_lo = ~8'hA5;
    step();
    chk("R3 done with full word", {{(W-1){1'b0}}, done}, 1);
    @(negedge clk); rst = 1'b1;
    step();
    chk("R1 reset overrides full word", {{(W-1){1'b0}}, done}, '0);
    chk("R6 word zero in reset", word, '0);
    @(negedge clk); rst = 1'b0;
    step();
    chk("R3 done rises again after reset", {{(W-1){1'b0}}, done}, 1);
    chk("R6 word after recovery", word, 8'hA5);
    @(negedge clk); rail_hi = '0; rail_lo = '0;
    step();
    chk("R4 done falls after recovery", {{(W-1){1'b0}}, done}, '0);
  endtask

  initial begin
    t_reset();
    t_fill_drain('0);
    t_fill_drain('1);
    t_fill_drain(8'h5C);
    t_fill_drain(8'h93);
    t_illegal();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule